// File: doc/BRIEF.md
# Scalar-Vector Memory Ordering Guard

This block sits between the load/store issue stage of a scalar core and the memory port of an attached vector unit. Every cycle it looks at four pending request classes (scalar load, scalar store, vector load, vector store) and decides which of them may issue. Ordering is kept by fixed blocking rules. A class may not start while a conflicting class still has operations outstanding, and a scalar store excludes all vector traffic. Outstanding work is tracked with saturating counters that are fed by the grants and by completion pulses.

The scalar data cache is write-through, so main memory always holds current scalar data. Only vector writes can leave stale lines in that cache. When the vector unit reports that a store has finished, it also gives the first and last byte address touched. The guard queues that range and walks it, issuing one line-aligned invalidate per cache line over a ready/valid handshake. A vector store counts as outstanding until the invalidate for its last line has been accepted. Until then, scalar loads cannot observe stale lines.

When a scalar and a vector request are both eligible in the same cycle, the scalar request wins.

Top module: `mem_order_guard`

## Requirements
- R1: `s_ld_gnt` is high exactly when `s_ld_req` is high and the vector-store counter is zero.
- R2: `s_st_gnt` is high exactly when all of these hold: `s_st_req` is high, the vector-load counter is zero, the vector-store counter is zero, and the scalar-store counter is below 15.
- R3: `v_ld_gnt` and `v_st_gnt` are never high while the scalar-store counter is nonzero, and each is also withheld while its own counter is at 15.
- R4: Scalar priority within a cycle. `v_ld_gnt` is low whenever `s_st_gnt` is high. `v_st_gnt` is low whenever `s_st_gnt` or `s_ld_gnt` is high.
- R5: Each counter is 4 bits wide, with the following rules:
  - In a cycle with an issue (request and grant both high) and no completion, the counter increases by one.
  - In a cycle with a completion and no issue, it decreases by one.
  - In a cycle with both, it is unchanged.
  - It never goes below 0 or above 15. A completion at 0 is ignored.
- R6: A vector store stays in the vector-store counter from its grant until the invalidate for the last line of its range has been accepted.
- R7: A `v_st_done` pulse carrying byte addresses `first` and `last` (last ≥ first) produces one invalidate for every 64-byte line from the line of `first` to the line of `last` inclusive. The invalidates come in ascending order and each `inv_addr` has its low 6 bits zero.
- R8: While `inv_valid` is high and `inv_ready` is low, `inv_valid` stays high and `inv_addr` is held. Completed ranges are walked in the order their completions arrived.
- R9: After reset all counters are zero and `inv_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_ld_req | input | 1 | Scalar load waiting to issue |
| s_st_req | input | 1 | Scalar store waiting to issue |
| v_ld_req | input | 1 | Vector load waiting to issue |
| v_st_req | input | 1 | Vector store waiting to issue |
| s_st_done | input | 1 | One scalar store finished |
| v_ld_done | input | 1 | One vector load finished |
| v_st_done | input | 1 | One vector store finished; its range is on `v_st_first`/`v_st_last` |
| v_st_first | input | ADDR_W | First byte address written by the finished vector store |
| v_st_last | input | ADDR_W | Last byte address written by the finished vector store |
| inv_ready | input | 1 | Scalar cache accepts an invalidate |
| s_ld_gnt | output | 1 | Scalar load may issue this cycle |
| s_st_gnt | output | 1 | Scalar store may issue this cycle |
| v_ld_gnt | output | 1 | Vector load may issue this cycle |
| v_st_gnt | output | 1 | Vector store may issue this cycle |
| inv_valid | output | 1 | Invalidate request present |
| inv_addr | output | ADDR_W | Line-aligned address to invalidate |

## Verification
Three kinds of same-cycle overlap are exercised:
- **Issue and completion on one counter.** A grant and a completion pulse on the same counter land in one cycle. Requests stay asserted while completion pulses are injected at random, and the counter must then hold.
- **Scalar and vector requests together.** These are provoked by raising all four requests at once when every counter is zero, where only the scalar grants may rise.
- **End of a range and start of the next store.** The accepted last invalidate of one range can coincide with a new vector-store completion pushing the next range.

A behavioural model built from counters and a queue of line ranges predicts every grant and every invalidate on every cycle, and any mismatch is reported.

// File: rtl/mog_pkg.sv
package mog_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;

endpackage

// File: rtl/mog_sat_counter.sv
module mog_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (inc && !dec && st_q.cnt != TOP) begin
            st_d.cnt = st_q.cnt + W'(1);
        end else if (dec && !inc && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/mog_range_fifo.sv
module mog_range_fifo #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_first,
    input  logic [LINE_W-1:0] push_last,
    input  logic              pop,
    output logic              empty,
    output logic [LINE_W-1:0] head_first,
    output logic [LINE_W-1:0] head_last
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW:0]   fill;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    logic [2*LINE_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.fill != (PW+1)'(DEPTH));
        do_pop  = pop && (st_q.fill != '0);
        if (do_push) st_d.wr = (st_q.wr == PW'(DEPTH-1)) ? '0 : st_q.wr + PW'(1);
        if (do_pop)  st_d.rd = (st_q.rd == PW'(DEPTH-1)) ? '0 : st_q.rd + PW'(1);
        if (do_push && !do_pop)      st_d.fill = st_q.fill + (PW+1)'(1);
        else if (do_pop && !do_push) st_d.fill = st_q.fill - (PW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= {push_first, push_last};
    end

    assign empty      = (st_q.fill == '0);
    assign head_first = mem_q[st_q.rd][2*LINE_W-1:LINE_W];
    assign head_last  = mem_q[st_q.rd][LINE_W-1:0];
endmodule

// File: rtl/mog_inval_walker.sv
module mog_inval_walker
    import mog_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_empty,
    input  logic [LINE_W-1:0] src_first,
    input  logic [LINE_W-1:0] src_last,
    output logic              src_pop,
    input  logic              inv_ready,
    output logic              inv_valid,
    output logic [LINE_W-1:0] inv_line,
    output logic              range_done
);
    typedef struct packed {
        walk_state_e       state;
        logic [LINE_W-1:0] cur;
        logic [LINE_W-1:0] last;
    } walk_t;

    walk_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        src_pop    = 1'b0;
        range_done = 1'b0;
        case (st_q.state)
            WALK_IDLE: begin
                if (!src_empty) begin
                    src_pop    = 1'b1;
                    st_d.state = WALK_BUSY;
                    st_d.cur   = src_first;
                    st_d.last  = src_last;
                end
            end
            default: begin
                if (inv_ready) begin
                    if (st_q.cur == st_q.last) begin
                        range_done = 1'b1;
                        st_d.state = WALK_IDLE;
                    end else begin
                        st_d.cur = st_q.cur + LINE_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: WALK_IDLE, cur: '0, last: '0};
        else        st_q <= st_d;
    end

    assign inv_valid = (st_q.state == WALK_BUSY);
    assign inv_line  = st_q.cur;
endmodule

// File: rtl/mem_order_guard.sv
module mem_order_guard #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ld_req,
    input  logic              s_st_req,
    input  logic              v_ld_req,
    input  logic              v_st_req,
    input  logic              s_st_done,
    input  logic              v_ld_done,
    input  logic              v_st_done,
    input  logic [ADDR_W-1:0] v_st_first,
    input  logic [ADDR_W-1:0] v_st_last,
    input  logic              inv_ready,
    output logic              s_ld_gnt,
    output logic              s_st_gnt,
    output logic              v_ld_gnt,
    output logic              v_st_gnt,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr
);
    localparam int OFF        = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - OFF;
    localparam int FIFO_DEPTH = 1 << CNT_W;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  s_st_cnt, v_ld_cnt, v_st_cnt;
    logic              fifo_empty, fifo_pop, range_done;
    logic [LINE_W-1:0] head_first, head_last, inv_line;
    logic              unused_low_bits;

    assign unused_low_bits = ^{v_st_first[OFF-1:0], v_st_last[OFF-1:0]};

    // issue rules with scalar priority inside a cycle
    always_comb begin
        s_ld_gnt = s_ld_req && (v_st_cnt == '0);
        s_st_gnt = s_st_req && (v_ld_cnt == '0) && (v_st_cnt == '0)
                   && (s_st_cnt != CNT_TOP);
        v_ld_gnt = v_ld_req && (s_st_cnt == '0) && !s_st_gnt
                   && (v_ld_cnt != CNT_TOP);
        v_st_gnt = v_st_req && (s_st_cnt == '0) && !s_st_gnt && !s_ld_gnt
                   && (v_st_cnt != CNT_TOP);
    end

    mog_sat_counter #(.W(CNT_W)) u_cnt_sst (
        .clk(clk), .rst_n(rst_n), .inc(s_st_gnt), .dec(s_st_done), .cnt(s_st_cnt));
    mog_sat_counter #(.W(CNT_W)) u_cnt_vld (
        .clk(clk), .rst_n(rst_n), .inc(v_ld_gnt), .dec(v_ld_done), .cnt(v_ld_cnt));
    mog_sat_counter #(.W(CNT_W)) u_cnt_vst (
        .clk(clk), .rst_n(rst_n), .inc(v_st_gnt), .dec(range_done), .cnt(v_st_cnt));

    mog_range_fifo #(.LINE_W(LINE_W), .DEPTH(FIFO_DEPTH)) u_ranges (
        .clk(clk), .rst_n(rst_n),
        .push(v_st_done),
        .push_first(v_st_first[ADDR_W-1:OFF]),
        .push_last(v_st_last[ADDR_W-1:OFF]),
        .pop(fifo_pop), .empty(fifo_empty),
        .head_first(head_first), .head_last(head_last));

    mog_inval_walker #(.LINE_W(LINE_W)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .src_empty(fifo_empty), .src_first(head_first), .src_last(head_last),
        .src_pop(fifo_pop), .inv_ready(inv_ready), .inv_valid(inv_valid),
        .inv_line(inv_line), .range_done(range_done));

    assign inv_addr = {inv_line, {OFF{1'b0}}};
endmodule

// File: rtl/mog_checker.sv
module mog_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_st_req,
    input logic              s_st_done,
    input logic              s_ld_gnt,
    input logic              s_st_gnt,
    input logic              v_ld_gnt,
    input logic              v_st_gnt,
    input logic              inv_valid,
    input logic              inv_ready,
    input logic [ADDR_W-1:0] inv_addr,
    input logic [CNT_W-1:0]  s_st_cnt,
    input logic [CNT_W-1:0]  v_ld_cnt,
    input logic [CNT_W-1:0]  v_st_cnt
);
    assert_sld_no_vst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_ld_gnt |-> (v_st_cnt == '0));

    assert_sst_no_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_st_gnt |-> (v_ld_cnt == '0) && (v_st_cnt == '0));

    assert_vec_no_sst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_ld_gnt || v_st_gnt) |-> (s_st_cnt == '0));

    assert_scalar_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_st_gnt || s_ld_gnt) |-> !v_st_gnt);

    assert_hold_on_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_st_req && s_st_gnt && s_st_done) |=> $stable(s_st_cnt));

    assert_inv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> inv_valid && $stable(inv_addr));
endmodule

bind mem_order_guard mog_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_st_req(s_st_req), .s_st_done(s_st_done),
    .s_ld_gnt(s_ld_gnt), .s_st_gnt(s_st_gnt), .v_ld_gnt(v_ld_gnt), .v_st_gnt(v_st_gnt),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr),
    .s_st_cnt(s_st_cnt), .v_ld_cnt(v_ld_cnt), .v_st_cnt(v_st_cnt));

// File: tb/mem_order_guard_test.sv
`timescale 1ns/1ps
module mem_order_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_ld_req = 0, s_st_req = 0, v_ld_req = 0, v_st_req = 0;
    logic s_st_done = 0, v_ld_done = 0, v_st_done = 0, inv_ready = 0;
    logic [31:0] v_st_first = '0, v_st_last = '0;
    logic s_ld_gnt, s_st_gnt, v_ld_gnt, v_st_gnt, inv_valid;
    logic [31:0] inv_addr;

    always #2 clk = ~clk;

    mem_order_guard uut (
        .clk(clk), .rst_n(rst_n), .s_ld_req(s_ld_req), .s_st_req(s_st_req),
        .v_ld_req(v_ld_req), .v_st_req(v_st_req), .s_st_done(s_st_done),
        .v_ld_done(v_ld_done), .v_st_done(v_st_done), .v_st_first(v_st_first),
        .v_st_last(v_st_last), .inv_ready(inv_ready), .s_ld_gnt(s_ld_gnt),
        .s_st_gnt(s_st_gnt), .v_ld_gnt(v_ld_gnt), .v_st_gnt(v_st_gnt),
        .inv_valid(inv_valid), .inv_addr(inv_addr));

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    int m_sst = 0, m_vld = 0, m_vst = 0, m_vst_fly = 0;
    bit m_act = 0;
    int m_cur = 0, m_end = 0;
    int q_first[$];
    int q_last[$];
    int inv_seen = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat(input int c, input bit inc, input bit dec);
        if (inc && !dec) return (c < 15) ? c + 1 : c;
        if (dec && !inc) return (c > 0) ? c - 1 : c;
        return c;
    endfunction

    // compare the current cycle and advance the model; called just after a negedge
    task automatic cycle();
        bit e_sld, e_sst, e_vld, e_vst, hs, fin, was_act;
        #1;
        e_sld = s_ld_req && m_vst == 0;
        e_sst = s_st_req && m_vld == 0 && m_vst == 0 && m_sst < 15;
        e_vld = v_ld_req && m_sst == 0 && !e_sst && m_vld < 15;
        e_vst = v_st_req && m_sst == 0 && !e_sst && !e_sld && m_vst < 15;
        chk(s_ld_gnt == e_sld, "R1 s_ld_gnt", int'(s_ld_gnt), int'(e_sld));
        chk(s_st_gnt == e_sst, "R2/R5 s_st_gnt", int'(s_st_gnt), int'(e_sst));
        chk(v_ld_gnt == e_vld, "R3/R4 v_ld_gnt", int'(v_ld_gnt), int'(e_vld));
        chk(v_st_gnt == e_vst, "R3/R4/R6 v_st_gnt", int'(v_st_gnt), int'(e_vst));
        chk(inv_valid == m_act, "R7/R8 inv_valid", int'(inv_valid), int'(m_act));
        if (m_act)
            chk(inv_addr == 32'(m_cur * 64), "R7 inv_addr", int'(inv_addr), m_cur * 64);
        hs = m_act && inv_ready;
        fin = hs && (m_cur == m_end);
        was_act = m_act;
        if (hs) begin
            inv_seen++;
            if (fin) m_act = 0; else m_cur++;
        end
        if (!was_act && q_first.size() > 0) begin
            m_cur = q_first.pop_front();
            m_end = q_last.pop_front();
            m_act = 1;
        end
        if (v_st_done) begin
            q_first.push_back(int'(v_st_first >> 6));
            q_last.push_back(int'(v_st_last >> 6));
            if (m_vst_fly > 0) m_vst_fly--;
        end
        m_sst = sat(m_sst, e_sst, s_st_done);
        m_vld = sat(m_vld, e_vld, v_ld_done);
        m_vst = sat(m_vst, e_vst, fin);
        if (e_vst) m_vst_fly++;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        s_ld_req = 0; s_st_req = 0; v_ld_req = 0; v_st_req = 0;
        s_st_done = 0; v_ld_done = 0; v_st_done = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(inv_valid == 0, "R9 inv_valid in reset", int'(inv_valid), 0);
        chk(s_ld_gnt == 0 && v_st_gnt == 0, "R9 grants idle", int'(s_ld_gnt), 0);
        rst_n = 1;
        @(negedge clk);

        // R4: all four requests at once with empty counters
        s_ld_req = 1; s_st_req = 1; v_ld_req = 1; v_st_req = 1;
        #1;
        chk(s_ld_gnt && s_st_gnt, "R4 scalar granted", int'(s_st_gnt), 1);
        chk(!v_ld_gnt && !v_st_gnt, "R4 vector held off", int'(v_ld_gnt | v_st_gnt), 0);
        #0;
        s_ld_req = 0; v_ld_req = 0; v_st_req = 0;
        cycle();
        // one scalar store in flight: complete it
        s_st_req = 0; s_st_done = 1; cycle(); idle_inputs();

        // R7/R6: one vector store spanning lines 0..4
        v_st_req = 1; cycle(); idle_inputs();
        inv_ready = 1;
        v_st_done = 1; v_st_first = 32'h3C; v_st_last = 32'h104;
        inv_seen = 0;
        cycle(); idle_inputs();
        s_ld_req = 1;
        repeat (10) cycle();
        chk(inv_seen == 5, "R7 invalidate count", inv_seen, 5);
        chk(s_ld_gnt == 1, "R6 load free after walk", int'(s_ld_gnt), 1);
        idle_inputs();

        // R5: saturation of the vector-load counter
        v_ld_req = 1;
        repeat (18) cycle();
        #1;
        chk(v_ld_gnt == 0, "R5 grant withheld at 15", int'(v_ld_gnt), 0);
        #0;
        v_ld_req = 0;
        repeat (15) begin v_ld_done = 1; cycle(); end
        v_ld_done = 0;
        // R5: spurious completion at zero is ignored
        s_st_done = 1; cycle(); s_st_done = 0;
        v_ld_req = 1;
        #1;
        chk(v_ld_gnt == 1, "R5 no underflow", int'(v_ld_gnt), 1);
        #0;
        cycle();
        v_ld_req = 0; v_ld_done = 1; cycle(); idle_inputs();

        // random traffic with backpressure and same-cycle issue/complete
        for (int i = 0; i < 4000; i++) begin
            s_ld_req  = ($urandom_range(0, 3) == 0);
            s_st_req  = ($urandom_range(0, 4) == 0);
            v_ld_req  = ($urandom_range(0, 2) == 0);
            v_st_req  = ($urandom_range(0, 2) == 0);
            s_st_done = (m_sst > 0) && ($urandom_range(0, 2) == 0);
            v_ld_done = (m_vld > 0) && ($urandom_range(0, 2) == 0);
            v_st_done = (m_vst_fly > 0) && ($urandom_range(0, 3) == 0);
            v_st_first = 32'($urandom_range(0, 4095));
            v_st_last  = v_st_first + 32'($urandom_range(0, 200));
            inv_ready = ($urandom_range(0, 2) != 0);
            cycle();
        end
        idle_inputs();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule